// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a multicycle processor core for a small subset of a 32-bit RISC instruction set. It steps each instruction through up to five phases (fetch, decode, execute, memory, writeback) and skips the phases an instruction does not use. A load takes five cycles. Register-register ALU operations, stores and jump-and-link take four. A conditional branch on equality takes three. Between phases the datapath keeps its partial results in its own holding registers. Each cycle this block drives the enables and multiplexer selects that decide which of those registers update.

The block reads the 7-bit opcode from the instruction register and the ALU zero flag. It drives write enables for the instruction register, the program counter, a saved-PC register, the register file and data memory. It also drives ALU operand selects, a result select, an ALU-operation class, and a flag that marks a branch-target PC update. During decode the instruction class is captured in the block, so later phases do not depend on the opcode input. The branch and jump target is computed during decode from the saved PC of the instruction itself, because the PC has already been advanced by 4 at that point.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: Asserting `rst_n` low forces the fetch phase at once. Release passes through a two-flop synchroniser, so the fetch outputs remain for two further cycles after `rst_n` rises. The first real fetch cycle then follows, and decode comes after it.
- R2: In fetch, `ir_we`, `pc_we` and `oldpc_we` are 1, `alu_a_sel`=1 (PC), `alu_b_sel`=2 (constant four), `result_sel`=2 (live ALU) and `alu_op`=0 (add). Fetch always lasts one cycle and is followed by decode.
- R3: In decode, all enables are 0, `alu_a_sel`=2 (saved PC), `alu_b_sel`=1 (immediate), `result_sel`=0 (ALU holding register) and `alu_op`=0. This forms the target address.
- R4: The instruction class is taken from `opcode` only during decode. Changes on `opcode` in later phases have no effect on the outputs or on the path.
- R5: Opcode 0110011 (register ALU) uses 4 cycles. In execute, selects are a=0 (rs1), b=0 (rs2) and `alu_op`=2 (function-field decode). In writeback, `rf_we`=1 and `result_sel`=0.
- R6: Opcode 0000011 (load) uses 5 cycles. In execute, a=0, b=1 and `alu_op`=0. In memory, all outputs are 0. In writeback, `rf_we`=1 and `result_sel`=1 (memory data).
- R7: Opcode 0100011 (store) uses 4 cycles. Execute matches the load. In memory, only `mem_we`=1. The store then returns to fetch with no register write.
- R8: Opcode 1100011 (branch-equal) uses 3 cycles. In execute, a=0, b=0, `alu_op`=1 (subtract), `pc_branch`=1, `result_sel`=0 and `pc_we` equals `alu_zero`. The next phase is fetch.
- R9: Opcode 1101111 (jump-and-link) uses 4 cycles. In execute, `pc_we`=1, `result_sel`=0, a=2, b=2 and `alu_op`=0. In writeback, `rf_we`=1 and `result_sel`=0.
- R10: Any other opcode returns to fetch directly after decode, with no enable asserted.
- R11: `rf_we` is asserted only in writeback, `mem_we` only in the memory phase of a store, and `ir_we` only in fetch. In phases with no listed value, every select is 0.
- R12: `alu_zero` affects nothing except `pc_we` in the execute phase of a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 7 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| ir_we | output | 1 | Instruction register write |
| pc_we | output | 1 | Program counter write |
| oldpc_we | output | 1 | Saved-PC register write |
| rf_we | output | 1 | Register file write |
| mem_we | output | 1 | Data memory write |
| pc_branch | output | 1 | Marks a conditional branch-target PC update |
| alu_a_sel | output | 2 | ALU A operand: 0 rs1, 1 PC, 2 saved PC |
| alu_b_sel | output | 2 | ALU B operand: 0 rs2, 1 immediate, 2 four |
| result_sel | output | 2 | Result: 0 ALU holding reg, 1 memory data, 2 live ALU |
| alu_op | output | 2 | ALU class: 0 add, 1 subtract, 2 function decode |

## Verification
The assertions are evaluated every cycle. They confirm that fetch is always followed by decode, that a branch always ends after execute, and that an unknown opcode always goes back to fetch after decode. They also confirm that the memory and writeback phases are entered only by classes that use them, that the register-file, memory and instruction-register writes appear only in their own phases, and that a PC write outside fetch comes only from a jump or a taken branch. The captured class may change only in decode. Only the directed scenarios can show the complete select pattern of each phase, the exact cycle count of each instruction class, and the two-cycle delay after reset release. They also show that an opcode change after decode is ignored and that a reset asserted in the middle of an instruction takes effect at once.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int unsigned OPC_W = 7;

  localparam logic [OPC_W-1:0] OPC_ALU_RR = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 7'b1101111;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } state_e;

  typedef enum logic [2:0] {
    CL_NONE   = 3'd0,
    CL_ALU    = 3'd1,
    CL_LOAD   = 3'd2,
    CL_STORE  = 3'd3,
    CL_BRANCH = 3'd4,
    CL_JUMP   = 3'd5
  } iclass_e;

  typedef enum logic [1:0] {
    SA_RS1   = 2'd0,
    SA_PC    = 2'd1,
    SA_OLDPC = 2'd2
  } srca_e;

  typedef enum logic [1:0] {
    SB_RS2  = 2'd0,
    SB_IMM  = 2'd1,
    SB_FOUR = 2'd2
  } srcb_e;

  typedef enum logic [1:0] {
    RS_ALUOUT  = 2'd0,
    RS_MEMDATA = 2'd1,
    RS_ALU     = 2'd2
  } res_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'd0,
    AOP_SUB   = 2'd1,
    AOP_FUNCT = 2'd2
  } aop_e;

  typedef struct packed {
    logic  ir_we;
    logic  pc_we;
    logic  oldpc_we;
    logic  rf_we;
    logic  mem_we;
    logic  pc_branch;
    srca_e a_sel;
    srcb_e b_sel;
    res_e  res_sel;
    aop_e  aop;
  } ctrl_t;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mc_op_classify.sv
module mc_op_classify
  import mc_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output iclass_e          cls
);

  always_comb begin
    case (opcode)
      OPC_ALU_RR: cls = CL_ALU;
      OPC_LOAD:   cls = CL_LOAD;
      OPC_STORE:  cls = CL_STORE;
      OPC_BRANCH: cls = CL_BRANCH;
      OPC_JUMP:   cls = CL_JUMP;
      default:    cls = CL_NONE;
    endcase
  end

endmodule

// File: rtl/mc_state_seq.sv
module mc_state_seq
  import mc_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iclass_e cls_live,
  output state_e  state_q,
  output iclass_e cls_q
);

  state_e state_d;
  logic   cls_en;

  assign cls_en = (state_q == ST_DECODE);

  // next-state process
  always_comb begin
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = (cls_live == CL_NONE) ? ST_FETCH : ST_EXEC;
      ST_EXEC: begin
        case (cls_q)
          CL_LOAD, CL_STORE: state_d = ST_MEM;
          CL_ALU, CL_JUMP:   state_d = ST_WB;
          default:           state_d = ST_FETCH;
        endcase
      end
      ST_MEM:    state_d = (cls_q == CL_LOAD) ? ST_WB : ST_FETCH;
      ST_WB:     state_d = ST_FETCH;
      default:   state_d = ST_FETCH;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      cls_q   <= CL_NONE;
    end else begin
      state_q <= state_d;
      if (cls_en) begin
        cls_q <= cls_live;
      end
    end
  end

  // R2: fetch is always a single cycle followed by decode
  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FETCH |=> state_q == ST_DECODE);

  // R4: captured class only moves in decode
  p_class_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != ST_DECODE |=> $stable(cls_q));

  // R6: memory phase reached only by load or store
  p_mem_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_MEM |-> (cls_q == CL_LOAD || cls_q == CL_STORE));

  // R5: writeback reached only by classes that write a register
  p_wb_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_WB |-> (cls_q == CL_ALU || cls_q == CL_LOAD || cls_q == CL_JUMP));

  // R8: a branch ends after execute
  p_branch_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && cls_q == CL_BRANCH) |=> state_q == ST_FETCH);

  // R10: unknown opcode goes back to fetch after decode
  p_unknown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE && cls_live == CL_NONE) |=> state_q == ST_FETCH);

endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
  import mc_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  state_e  state,
  input  iclass_e cls,
  input  logic    alu_zero,
  output ctrl_t   ctrl
);

  always_comb begin
    ctrl = '0;
    case (state)
      ST_FETCH: begin
        ctrl.ir_we    = 1'b1;
        ctrl.pc_we    = 1'b1;
        ctrl.oldpc_we = 1'b1;
        ctrl.a_sel    = SA_PC;
        ctrl.b_sel    = SB_FOUR;
        ctrl.res_sel  = RS_ALU;
        ctrl.aop      = AOP_ADD;
      end
      ST_DECODE: begin
        ctrl.a_sel   = SA_OLDPC;
        ctrl.b_sel   = SB_IMM;
        ctrl.res_sel = RS_ALUOUT;
        ctrl.aop     = AOP_ADD;
      end
      ST_EXEC: begin
        case (cls)
          CL_ALU: begin
            ctrl.a_sel = SA_RS1;
            ctrl.b_sel = SB_RS2;
            ctrl.aop   = AOP_FUNCT;
          end
          CL_LOAD, CL_STORE: begin
            ctrl.a_sel = SA_RS1;
            ctrl.b_sel = SB_IMM;
            ctrl.aop   = AOP_ADD;
          end
          CL_BRANCH: begin
            ctrl.a_sel     = SA_RS1;
            ctrl.b_sel     = SB_RS2;
            ctrl.aop       = AOP_SUB;
            ctrl.res_sel   = RS_ALUOUT;
            ctrl.pc_branch = 1'b1;
            ctrl.pc_we     = alu_zero;
          end
          CL_JUMP: begin
            ctrl.a_sel   = SA_OLDPC;
            ctrl.b_sel   = SB_FOUR;
            ctrl.aop     = AOP_ADD;
            ctrl.res_sel = RS_ALUOUT;
            ctrl.pc_we   = 1'b1;
          end
          default: ctrl = '0;
        endcase
      end
      ST_MEM: begin
        ctrl.mem_we = (cls == CL_STORE);
      end
      ST_WB: begin
        ctrl.rf_we   = 1'b1;
        ctrl.res_sel = (cls == CL_LOAD) ? RS_MEMDATA : RS_ALUOUT;
      end
      default: ctrl = '0;
    endcase
  end

  // R11: register write only in writeback
  p_rfwe_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.rf_we |-> state == ST_WB);

  // R11: instruction register loads only in fetch
  p_irwe_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ir_we |-> state == ST_FETCH);

  // R7: memory write only in the memory phase of a store
  p_memwe_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mem_we |-> (state == ST_MEM && cls == CL_STORE));

  // R12: PC write outside fetch only from a jump or a taken branch
  p_pcwe_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.pc_we && state != ST_FETCH) |->
      (state == ST_EXEC && (cls == CL_JUMP || (cls == CL_BRANCH && alu_zero))));

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_zero,
  output logic             ir_we,
  output logic             pc_we,
  output logic             oldpc_we,
  output logic             rf_we,
  output logic             mem_we,
  output logic             pc_branch,
  output logic [1:0]       alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       result_sel,
  output logic [1:0]       alu_op
);

  logic    rst_int_n;
  iclass_e cls_live;
  iclass_e cls_q;
  state_e  state_q;
  ctrl_t   ctrl;

  mc_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mc_op_classify classify_i (
    .opcode (opcode),
    .cls    (cls_live)
  );

  mc_state_seq seq_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cls_live (cls_live),
    .state_q  (state_q),
    .cls_q    (cls_q)
  );

  mc_out_decode dec_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .state    (state_q),
    .cls      (cls_q),
    .alu_zero (alu_zero),
    .ctrl     (ctrl)
  );

  assign ir_we      = ctrl.ir_we;
  assign pc_we      = ctrl.pc_we;
  assign oldpc_we   = ctrl.oldpc_we;
  assign rf_we      = ctrl.rf_we;
  assign mem_we     = ctrl.mem_we;
  assign pc_branch  = ctrl.pc_branch;
  assign alu_a_sel  = ctrl.a_sel;
  assign alu_b_sel  = ctrl.b_sel;
  assign result_sel = ctrl.res_sel;
  assign alu_op     = ctrl.aop;

endmodule

// File: tb/mc_ctrl_fsm_tb_top.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_tb_top;

  localparam logic [6:0] OP_R   = 7'b0110011;
  localparam logic [6:0] OP_LD  = 7'b0000011;
  localparam logic [6:0] OP_ST  = 7'b0100011;
  localparam logic [6:0] OP_BR  = 7'b1100011;
  localparam logic [6:0] OP_J   = 7'b1101111;
  localparam logic [6:0] OP_BAD = 7'b0010011;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] opcode = OP_BAD;
  logic       alu_zero = 1'b0;
  logic ir_we, pc_we, oldpc_we, rf_we, mem_we, pc_branch;
  logic [1:0] alu_a_sel, alu_b_sel, result_sel, alu_op;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mc_ctrl_fsm dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
    .ir_we(ir_we), .pc_we(pc_we), .oldpc_we(oldpc_we), .rf_we(rf_we),
    .mem_we(mem_we), .pc_branch(pc_branch), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .result_sel(result_sel), .alu_op(alu_op)
  );

  wire [13:0] obs = {ir_we, pc_we, oldpc_we, rf_we, mem_we, pc_branch,
                     alu_a_sel, alu_b_sel, result_sel, alu_op};

  // fields: ir pc oldpc rf mem br | a b res op
  function automatic logic [13:0] pk(input logic ir, input logic pc, input logic opc,
                                     input logic rf, input logic mw, input logic br,
                                     input logic [1:0] a, input logic [1:0] b,
                                     input logic [1:0] r, input logic [1:0] o);
    return {ir, pc, opc, rf, mw, br, a, b, r, o};
  endfunction

  function automatic logic [13:0] e_fetch();  return pk(1,1,1,0,0,0,2'd1,2'd2,2'd2,2'd0); endfunction
  function automatic logic [13:0] e_decode(); return pk(0,0,0,0,0,0,2'd2,2'd1,2'd0,2'd0); endfunction
  function automatic logic [13:0] e_idle();   return pk(0,0,0,0,0,0,2'd0,2'd0,2'd0,2'd0); endfunction
  function automatic logic [13:0] e_r_ex();   return pk(0,0,0,0,0,0,2'd0,2'd0,2'd0,2'd2); endfunction
  function automatic logic [13:0] e_addr();   return pk(0,0,0,0,0,0,2'd0,2'd1,2'd0,2'd0); endfunction
  function automatic logic [13:0] e_wb_alu(); return pk(0,0,0,1,0,0,2'd0,2'd0,2'd0,2'd0); endfunction
  function automatic logic [13:0] e_wb_mem(); return pk(0,0,0,1,0,0,2'd0,2'd0,2'd1,2'd0); endfunction
  function automatic logic [13:0] e_st_mem(); return pk(0,0,0,0,1,0,2'd0,2'd0,2'd0,2'd0); endfunction
  function automatic logic [13:0] e_br_ex(input logic z);
    return pk(0,z,0,0,0,1,2'd0,2'd0,2'd0,2'd1);
  endfunction
  function automatic logic [13:0] e_j_ex();   return pk(0,1,0,0,0,0,2'd2,2'd2,2'd0,2'd0); endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // called just after a falling edge; checks, then moves to the next falling edge
  task automatic chk(input logic [13:0] exp, input string req, input string what);
    #1;
    n_chk++;
    if (obs !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, obs, exp);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; opcode = OP_BAD; alu_zero = 1'b0;
    repeat (3) @(negedge clk);
    chk(e_fetch(), "R1", "held in reset");
    rst_n = 1'b1;
    chk(e_fetch(), "R1", "release sync cycle 1");
    chk(e_fetch(), "R1", "release sync cycle 2");
  endtask

  task automatic t_rtype();
    opcode = OP_R; alu_zero = 1'b1;   // zero flag must be ignored (R12)
    chk(e_fetch(),  "R2", "alu fetch");
    chk(e_decode(), "R3", "alu decode");
    chk(e_r_ex(),   "R5 R12", "alu execute");
    chk(e_wb_alu(), "R5 R11", "alu writeback");
    alu_zero = 1'b0;
  endtask

  task automatic t_load();
    opcode = OP_LD; alu_zero = 1'b1;
    chk(e_fetch(),  "R2", "load fetch");
    chk(e_decode(), "R3", "load decode");
    chk(e_addr(),   "R6 R12", "load execute");
    chk(e_idle(),   "R6 R11", "load memory");
    chk(e_wb_mem(), "R6", "load writeback");
    alu_zero = 1'b0;
  endtask

  task automatic t_store();
    opcode = OP_ST;
    chk(e_fetch(),  "R2", "store fetch");
    chk(e_decode(), "R3", "store decode");
    chk(e_addr(),   "R7", "store execute");
    chk(e_st_mem(), "R7", "store memory");
  endtask

  task automatic t_branch(input logic z);
    opcode = OP_BR; alu_zero = 1'b0;
    chk(e_fetch(),  "R2", "branch fetch");
    chk(e_decode(), "R3", "branch decode");
    alu_zero = z;
    chk(e_br_ex(z), "R8", z ? "branch taken" : "branch not taken");
    alu_zero = 1'b0;
  endtask

  task automatic t_jump();
    opcode = OP_J;
    chk(e_fetch(),  "R2", "jump fetch");
    chk(e_decode(), "R3", "jump decode");
    chk(e_j_ex(),   "R9", "jump execute");
    chk(e_wb_alu(), "R9", "jump writeback");
  endtask

  task automatic t_unknown();
    opcode = OP_BAD;
    chk(e_fetch(),  "R2", "unknown fetch");
    chk(e_decode(), "R10", "unknown decode");
    chk(e_fetch(),  "R10", "unknown back to fetch");
    chk(e_decode(), "R10", "unknown decode again");
  endtask

  task automatic t_opcode_swap();
    opcode = OP_LD;
    chk(e_fetch(),  "R2", "swap fetch");
    chk(e_decode(), "R3", "swap decode");
    opcode = OP_BR; alu_zero = 1'b1;
    chk(e_addr(),   "R4", "swap execute stays load");
    opcode = OP_ST;
    chk(e_idle(),   "R4", "swap memory no store write");
    chk(e_wb_mem(), "R4", "swap writeback stays load");
    alu_zero = 1'b0;
  endtask

  task automatic t_reset_mid();
    opcode = OP_LD;
    chk(e_fetch(),  "R2", "mid-reset fetch");
    chk(e_decode(), "R3", "mid-reset decode");
    rst_n = 1'b0;
    chk(e_fetch(), "R1", "async reset in execute");
    chk(e_fetch(), "R1", "still in reset");
    rst_n = 1'b1;
    chk(e_fetch(), "R1", "release sync cycle 1");
    chk(e_fetch(), "R1", "release sync cycle 2");
  endtask

  initial begin
    t_reset();
    t_rtype();
    t_load();
    t_store();
    t_branch(1'b1);
    t_branch(1'b0);
    t_jump();
    t_unknown();
    t_opcode_swap();
    t_reset_mid();
    t_rtype();
    report();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got still running expected finished");
      report();
    end
  end

endmodule